// File: doc/BRIEF.md
# Progressive Raster Timing Generator

This block drives the sync and framing signals of a progressive video output. It keeps a horizontal pixel counter and a vertical line counter. A pixel-clock enable advances them, so the block can sit in a faster system clock domain. It compares both counters against a small set of timing registers and produces horizontal sync, vertical sync, data-enable, the coordinates of the current active pixel, and one-clock strobes that mark the first and the last active pixel of a frame.

Every horizontal and vertical position is an absolute count measured from the leading edge of the sync pulse. The display start equals sync width plus back porch. The display end equals display start plus the active size. The total equals display end plus the front porch.

Software writes the timing through a simple write port into a staging copy. The running copy takes the staged values only on a frame boundary, or while the block is disabled, so a mode change never produces a broken frame. The active area is at most 2048 by 2048, and only progressive timing is generated.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls with `enable` low, all outputs are low and `pix_x`/`pix_y` are zero. The running and staged timing take the parameter defaults.
- R2: A write (`cfg_we` high) stores `cfg_wdata` into the staged timing according to `cfg_sel`, as follows:
  - 0 = totals: horizontal in bits 31:16, vertical in bits 15:0.
  - 1 = horizontal window: start in 31:16, end in 15:0.
  - 2 = vertical window: the same layout, in lines.
  - 3 = hsync width in the low bits.
  - 4 = vsync width in the low bits.
  - Other codes are ignored.
- R3: The pixel counter runs 0..htotal-1, and the line counter advances once when the pixel counter wraps, running 0..vtotal-1. `hsync` is high while the pixel count is below the hsync width, and `vsync` is high while the line count is below the vsync width. All outputs are registered one clock after the enabled cycle whose counts they show.
- R4: `de` is high when the pixel count lies in [hstart, hend) and the line count lies in [vstart, vend).
- R5: While `de` is high, `pix_x` = pixel count − hstart and `pix_y` = line count − vstart; otherwise both are zero.
- R6: `sof` is high for exactly one clock, for the pixel at (hstart, vstart).
- R7: `eof` is high for exactly one clock, for the pixel at (hend, vend−1), which is the pixel just after the last active one. The horizontal front porch must therefore be at least one.
- R8: Staged timing is copied to the running timing only when both counters wrap to zero together. A write in the middle of a frame does not change that frame.
- R9: While `enable` is low, the counters are held at zero, the staged timing is copied to the running timing on every clock, and all outputs are low from the next clock on.
- R10: On an enabled clock with `pix_ce` low, the counters and the level outputs hold, and `sof`/`eof` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low holds the counters at zero |
| pix_ce | input | 1 | Pixel-clock enable |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 3 | Timing register select |
| cfg_wdata | input | 32 | Timing register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | 16 | Active pixel column |
| pix_y | output | 16 | Active line row |
| sof | output | 1 | First active pixel strobe |
| eof | output | 1 | Strobe after the last active pixel |

## Verification
A counter that wraps at the wrong value or skips a line changes the `hsync` spacing or the `vsync` phase within one line, and so changes the place where `de` and the coordinates appear. A reference model that steps in lockstep exposes such a fault on the first wrong clock. A shadow copy that is loaded too early shows a new line length inside the current frame. A strobe condition that is wrong misplaces `sof` or `eof` against the first `de` pixel of the same frame. Stalls on `pix_ce` and disabled periods are mixed in, so outputs that drift while held are seen on the next comparison.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int CW = 16;
  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t htot;
    cnt_t vtot;
    cnt_t hds;
    cnt_t hde;
    cnt_t vds;
    cnt_t vde;
    cnt_t hsw;
    cnt_t vsw;
  } rtg_timing_t;

  typedef enum logic [2:0] {
    SEL_TOTAL = 3'd0,
    SEL_HWIN  = 3'd1,
    SEL_VWIN  = 3'd2,
    SEL_HSW   = 3'd3,
    SEL_VSW   = 3'd4
  } rtg_sel_e;
endpackage

// File: rtl/rtg_cfg_regs.sv
module rtg_cfg_regs
  import rtg_pkg::*;
#(
  parameter rtg_timing_t INIT = '0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        load,
  output rtg_timing_t live
);
  rtg_timing_t staged;
  cnt_t        hi_f;
  cnt_t        lo_f;

  assign hi_f = wr_data[16 +: CW];
  assign lo_f = wr_data[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      staged <= INIT;
      live   <= INIT;
    end else begin
      if (load) live <= staged;
      if (wr_en) begin
        case (rtg_sel_e'(wr_sel))
          SEL_TOTAL: begin staged.htot <= hi_f; staged.vtot <= lo_f; end
          SEL_HWIN:  begin staged.hds  <= hi_f; staged.hde  <= lo_f; end
          SEL_VWIN:  begin staged.vds  <= hi_f; staged.vde  <= lo_f; end
          SEL_HSW:   staged.hsw <= lo_f;
          SEL_VSW:   staged.vsw <= lo_f;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtg_axis_ctr.sv
module rtg_axis_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign wrap = (nxt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= wrap ? '0 : nxt[W-1:0];
  end
endmodule

// File: rtl/rtg_out_stage.sv
module rtg_out_stage
  import rtg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        ce,
  input  cnt_t        hcnt,
  input  cnt_t        vcnt,
  input  rtg_timing_t cfg,
  output logic        hsync_q,
  output logic        vsync_q,
  output logic        de_q,
  output cnt_t        x_q,
  output cnt_t        y_q,
  output logic        sof_q,
  output logic        eof_q
);
  logic h_act, v_act, act, first_px, after_last;

  always_comb begin
    h_act      = (hcnt >= cfg.hds) && (hcnt < cfg.hde);
    v_act      = (vcnt >= cfg.vds) && (vcnt < cfg.vde);
    act        = h_act && v_act;
    first_px   = (hcnt == cfg.hds) && (vcnt == cfg.vds);
    after_last = (hcnt == cfg.hde) && (vcnt == cfg.vde - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hsync_q <= 1'b0;
      vsync_q <= 1'b0;
      de_q    <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
    end else if (ce) begin
      hsync_q <= hcnt < cfg.hsw;
      vsync_q <= vcnt < cfg.vsw;
      de_q    <= act;
      x_q     <= act ? cnt_t'(hcnt - cfg.hds) : '0;
      y_q     <= act ? cnt_t'(vcnt - cfg.vds) : '0;
      sof_q   <= first_px;
      eof_q   <= after_last;
    end else begin
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int DEF_HTOT = 20,
  parameter int DEF_VTOT = 12,
  parameter int DEF_HDS  = 5,
  parameter int DEF_HDE  = 15,
  parameter int DEF_VDS  = 3,
  parameter int DEF_VDE  = 10,
  parameter int DEF_HSW  = 2,
  parameter int DEF_VSW  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          pix_ce,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          sof,
  output logic          eof
);
  localparam rtg_timing_t INIT = '{
    htot: cnt_t'(DEF_HTOT), vtot: cnt_t'(DEF_VTOT),
    hds:  cnt_t'(DEF_HDS),  hde:  cnt_t'(DEF_HDE),
    vds:  cnt_t'(DEF_VDS),  vde:  cnt_t'(DEF_VDE),
    hsw:  cnt_t'(DEF_HSW),  vsw:  cnt_t'(DEF_VSW)
  };

  rtg_timing_t live;
  cnt_t        hcnt, vcnt;
  logic        h_wrap, v_wrap, h_step, v_step, frame_wrap, cfg_load;

  assign h_step     = enable & pix_ce;
  assign v_step     = h_step & h_wrap;
  assign frame_wrap = v_step & v_wrap;
  assign cfg_load   = ~enable | frame_wrap;

  rtg_cfg_regs #(.INIT(INIT)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .load(cfg_load), .live(live)
  );

  rtg_axis_ctr #(.W(CW)) u_hctr (
    .clk(clk), .rst(rst), .clr(~enable), .step(h_step),
    .limit(live.htot), .cnt(hcnt), .wrap(h_wrap)
  );

  rtg_axis_ctr #(.W(CW)) u_vctr (
    .clk(clk), .rst(rst), .clr(~enable), .step(v_step),
    .limit(live.vtot), .cnt(vcnt), .wrap(v_wrap)
  );

  rtg_out_stage u_out (
    .clk(clk), .rst(rst), .en(enable), .ce(pix_ce),
    .hcnt(hcnt), .vcnt(vcnt), .cfg(live),
    .hsync_q(hsync), .vsync_q(vsync), .de_q(de),
    .x_q(pix_x), .y_q(pix_y), .sof_q(sof), .eof_q(eof)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic enable,
  input logic pix_ce,
  input logic hsync,
  input logic vsync,
  input logic de,
  input cnt_t pix_x,
  input cnt_t pix_y,
  input logic sof,
  input logic eof
);
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!hsync && !vsync && !de && !sof && !eof));

  // R6
  sof_single_chk: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

  // R7
  eof_single_chk: assert property (@(posedge clk) disable iff (rst)
    eof |=> !eof);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && !pix_ce) |=> ($stable(de) && $stable(pix_x) && $stable(pix_y)
                             && $stable(hsync) && !sof && !eof));

  // R5
  coord_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pix_x == '0 && pix_y == '0));

  // R6
  sof_origin_chk: assert property (@(posedge clk) disable iff (rst)
    sof |-> (de && pix_x == '0 && pix_y == '0));
endmodule

bind raster_timing_gen rtg_checker u_rtg_chk (
  .clk(clk), .rst(rst), .enable(enable), .pix_ce(pix_ce),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
  .sof(sof), .eof(eof)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
module raster_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        pix_ce = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hsync, vsync, de, sof, eof;
  logic [15:0] pix_x, pix_y;

  always #2.5 clk = ~clk;

  raster_timing_gen dut_i (
    .clk(clk), .rst(rst), .enable(enable), .pix_ce(pix_ce),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
    .sof(sof), .eof(eof)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: index 0 htot 1 vtot 2 hds 3 hde 4 vds 5 vde 6 hsw 7 vsw
  int live[8], stg[8];
  int hc, vc;
  bit m_hs, m_vs, m_de, m_sof, m_eof;
  int m_x, m_y;
  bit ld;

  always @(posedge clk) begin
    if (rst) begin
      stg = '{20, 12, 5, 15, 3, 10, 2, 1};
      live = stg;
      hc = 0; vc = 0;
      {m_hs, m_vs, m_de, m_sof, m_eof} = '0;
      m_x = 0; m_y = 0;
    end else begin
      if (!enable) begin
        {m_hs, m_vs, m_de, m_sof, m_eof} = '0;
        m_x = 0; m_y = 0;
      end else if (pix_ce) begin
        m_hs  = hc < live[6];
        m_vs  = vc < live[7];
        m_de  = hc >= live[2] && hc < live[3] && vc >= live[4] && vc < live[5];
        m_x   = m_de ? hc - live[2] : 0;
        m_y   = m_de ? vc - live[4] : 0;
        m_sof = hc == live[2] && vc == live[4];
        m_eof = hc == live[3] && vc == live[5] - 1;
      end else begin
        m_sof = 0; m_eof = 0;
      end
      ld = 0;
      if (!enable) begin hc = 0; vc = 0; ld = 1; end
      else if (pix_ce) begin
        if (hc + 1 >= live[0]) begin
          hc = 0;
          if (vc + 1 >= live[1]) begin vc = 0; ld = 1; end
          else vc++;
        end else hc++;
      end
      if (ld) live = stg;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: begin stg[0] = cfg_wdata[31:16]; stg[1] = cfg_wdata[15:0]; end
          3'd1: begin stg[2] = cfg_wdata[31:16]; stg[3] = cfg_wdata[15:0]; end
          3'd2: begin stg[4] = cfg_wdata[31:16]; stg[5] = cfg_wdata[15:0]; end
          3'd3: stg[6] = cfg_wdata[15:0];
          3'd4: stg[7] = cfg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // Lockstep comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R3 hsync", hsync, m_hs);
      chk("R3 vsync", vsync, m_vs);
      chk("R4 de", de, m_de);
      chk("R5 x", pix_x, m_x);
      chk("R5 y", pix_y, m_y);
      chk("R6 sof", sof, m_sof);
      chk("R7 eof", eof, m_eof);
    end
  end

  task automatic wr(input int sel, input int hi, input int lo);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = {16'(hi), 16'(lo)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rise_hsync();
    logic prev = hsync;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (hsync && !prev) return;
      prev = hsync;
    end
  endtask

  task automatic measure_line(output int len);
    logic prev;
    wait_rise_hsync();
    prev = hsync;
    len = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      len++;
      if (hsync && !prev) return;
      prev = hsync;
    end
  endtask

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 hsync", hsync, 0);
    chk("R1 de", de, 0);
    chk("R1 x", pix_x, 0);
    chk("R1 sof", sof, 0);
    cmp_on = 1;

    enable = 1'b1; pix_ce = 1'b1;
    // R3: default line length 20
    measure_line(len);
    chk("R3 line length", len, 20);
    repeat (480) @(negedge clk);

    // R2 / R8: new timing staged mid-frame
    wr(0, 14, 9);
    wr(1, 4, 12);
    wr(2, 2, 8);
    wr(3, 0, 3);
    wr(4, 0, 2);
    wr(6, 1, 1); // unused code, ignored
    measure_line(len);
    chk("R8 old line length kept", len, 20);
    @(negedge clk);
    while (!(vsync)) @(negedge clk);
    measure_line(len);
    chk("R2 new line length", len, 14);
    repeat (300) @(negedge clk);

    // R10: pixel enable every third clock
    for (int i = 0; i < 900; i++) begin
      @(negedge clk);
      pix_ce = (i % 3 == 0);
    end
    @(negedge clk);
    pix_ce = 1'b1;
    repeat (50) @(negedge clk);

    // R9: disable mid-frame, stage a new mode meanwhile
    enable = 1'b0;
    wr(0, 10, 7);
    wr(1, 2, 9);
    wr(2, 2, 6);
    wr(3, 0, 1);
    wr(4, 0, 1);
    chk("R9 hsync off", hsync, 0);
    chk("R9 de off", de, 0);
    chk("R9 vsync off", vsync, 0);
    enable = 1'b1;
    measure_line(len);
    chk("R9 mode taken while disabled", len, 10);
    repeat (400) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule